// File: doc/BRIEF.md
# ASCII Decimal Adjust Unit

This unit performs the three unpacked-BCD correction steps that a processor applies to its 16-bit accumulator pair. The pair is treated as a high byte and a low byte. One step fixes a digit after an addition. One step packs two digits into a binary value before a division. One step splits a binary value into two digits after a multiplication. The caller supplies the accumulator, the incoming auxiliary-carry flag and a base byte. It receives the adjusted accumulator, five flags and a divide-error indication.

Two mode pins select variants. `legacy_mode` picks the oldest addition correction, in which the +6 is applied to the low byte only. When the pin is clear, the +6 is applied to the whole 16-bit pair. `force_ten` replaces any base operand with ten, which matches cores that only understand the decimal form.

Operands enter on a valid/ready handshake and the result leaves on a second one. An operand is taken on a clock edge where `in_valid` and `in_ready` are both high. Its result appears on the next edge with `out_valid` high. The result holds, unchanged, for as long as `out_ready` stays low. `in_ready` is high whenever the output register is empty or is being emptied in the same cycle. A new operand can therefore be taken every cycle while the consumer keeps `out_ready` high.

Top module: `ascii_adjust_unit`

## Requirements
- R1: With `op` = 2'b00 (add adjust), the correction path is taken exactly when the low nibble of the low byte exceeds 9 or `af_in` is 1.
- R2: On the correction path with `legacy_mode` = 0, 6 is added to the full 16-bit pair, so a carry out of the low byte reaches the high byte. The high byte is then incremented, and `cf` and `af_out` are both 1.
- R3: On the correction path with `legacy_mode` = 1, 6 is added to the low byte only, with no carry into the high byte. The high byte is then incremented, and `cf` and `af_out` are both 1.
- R4: On the add-adjust path without correction, `cf` and `af_out` are 0 and the high byte is unchanged. In every add-adjust result, bits 7:4 of the low byte are 0.
- R5: With `op` = 2'b01 (divide prepare), the low byte becomes (high × base + low) mod 256 and the high byte becomes 0. `sf` is bit 7 of the new low byte, `zf` is 1 when that byte is 0, and `pf` is 1 when that byte has an even number of one bits.
- R6: With `op` = 2'b10 (multiply split) and a nonzero base, the high byte becomes low / base and the low byte becomes low mod base. `sf`, `zf` and `pf` are set from the new low byte as in R5.
- R7: When `force_ten` is 1, both the divide-prepare and the multiply-split operations use base 10 whatever the value of `base`.
- R8: A multiply split with an effective base of 0 sets `div_err` to 1, returns the accumulator unchanged and drives all flags to 0. Every other operation returns `div_err` = 0.
- R9: Flags with no defined meaning are 0. For add adjust these are `sf`, `zf` and `pf`. For the other two operations they are `cf` and `af_out`. `op` = 2'b11 returns the accumulator unchanged with all flags 0.
- R10: A result appears with `out_valid` high on the edge after its operand is accepted. While `out_valid` is high and `out_ready` is low, `in_ready` is 0 and every result output holds.
- R11: After reset, `out_valid` is 0, all result outputs are 0 and `in_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand valid |
| in_ready | output | 1 | Unit can take an operand |
| op | input | 2 | 00 add adjust, 01 divide prepare, 10 multiply split, 11 pass |
| base | input | 8 | Base operand for the divide-prepare and multiply-split operations |
| ax_in | input | 16 | Accumulator pair, high byte in bits 15:8 |
| af_in | input | 1 | Incoming auxiliary-carry flag |
| legacy_mode | input | 1 | Apply the +6 to the low byte only |
| force_ten | input | 1 | Use base 10 |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| ax_out | output | 16 | Adjusted accumulator |
| cf | output | 1 | Carry flag |
| af_out | output | 1 | Auxiliary-carry flag |
| sf | output | 1 | Sign flag |
| zf | output | 1 | Zero flag |
| pf | output | 1 | Parity flag (even) |
| div_err | output | 1 | Zero-base multiply split |

## Verification
Every result is due exactly one edge after its operand is accepted, because only the output register lies on the path. The bench therefore drives each operand at a falling edge and lets one rising edge take it in. It compares the outputs at the next falling edge, which is after the capture edge and before the register can change again. In the back-pressure case the consumer stays stalled for several cycles. The same result is compared at each falling edge during the stall, and again after `out_ready` rises. The next operand, held waiting on the input the whole time, is compared one edge after it is finally taken.

// File: rtl/aau_pkg.sv
package aau_pkg;
  localparam int BW = 8;
  localparam int AW = 2 * BW;
  localparam logic [3:0] NIB_LIMIT = 4'd9;
  localparam logic [BW-1:0] DEC_FIX = BW'(6);

  typedef enum logic [1:0] {
    AAU_ADD   = 2'b00,
    AAU_DPREP = 2'b01,
    AAU_MSPLT = 2'b10,
    AAU_PASS  = 2'b11
  } aau_op_e;

  typedef struct packed {
    logic [AW-1:0] ax;
    logic cf;
    logic af;
    logic sf;
    logic zf;
    logic pf;
    logic derr;
  } aau_res_t;

  function automatic logic [2:0] szp_of(input logic [BW-1:0] v);
    return {v[BW-1], (v == '0), ~^v};
  endfunction
endpackage

// File: rtl/aau_add_adj.sv
module aau_add_adj
  import aau_pkg::*;
(
  input  logic [AW-1:0] ax,
  input  logic          af_in,
  input  logic          legacy,
  output aau_res_t      res
);
  logic          need_fix;
  logic [AW-1:0] sum;

  always_comb begin
    need_fix = (ax[3:0] > NIB_LIMIT) || af_in;
    sum      = ax;
    if (need_fix) begin
      if (legacy) sum[BW-1:0] = ax[BW-1:0] + DEC_FIX;
      else        sum = ax + AW'(DEC_FIX);
      sum[AW-1:BW] = sum[AW-1:BW] + BW'(1);
    end
    res     = '0;
    res.ax  = {sum[AW-1:BW], {(BW-4){1'b0}}, sum[3:0]};
    res.cf  = need_fix;
    res.af  = need_fix;
  end
endmodule

// File: rtl/aau_base_adj.sv
module aau_base_adj
  import aau_pkg::*;
#(
  parameter bit SPLIT = 1'b0
) (
  input  logic [AW-1:0] ax,
  input  logic [BW-1:0] b,
  output aau_res_t      res
);
  logic [BW-1:0] hi, lo;
  assign hi = ax[AW-1:BW];
  assign lo = ax[BW-1:0];

  generate
    if (SPLIT) begin : g_split
      logic [BW-1:0] q, r;
      always_comb begin
        q   = (b == '0) ? '0 : lo / b;
        r   = (b == '0) ? lo : lo % b;
        res = '0;
        if (b == '0) begin
          res.ax   = ax;
          res.derr = 1'b1;
        end else begin
          res.ax = {q, r};
          {res.sf, res.zf, res.pf} = szp_of(r);
        end
      end
    end else begin : g_pack
      logic [AW-1:0] wide;
      always_comb begin
        wide   = AW'(hi) * AW'(b) + AW'(lo);
        res    = '0;
        res.ax = {{BW{1'b0}}, wide[BW-1:0]};
        {res.sf, res.zf, res.pf} = szp_of(wide[BW-1:0]);
      end
    end
  endgenerate
endmodule

// File: rtl/ascii_adjust_unit.sv
module ascii_adjust_unit
  import aau_pkg::*;
#(
  parameter int unsigned FIXED_BASE = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [1:0]    op,
  input  logic [7:0]    base,
  input  logic [15:0]   ax_in,
  input  logic          af_in,
  input  logic          legacy_mode,
  input  logic          force_ten,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [15:0]   ax_out,
  output logic          cf,
  output logic          af_out,
  output logic          sf,
  output logic          zf,
  output logic          pf,
  output logic          div_err
);
  localparam logic [BW-1:0] TEN = BW'(FIXED_BASE);

  logic [BW-1:0] eff_base;
  aau_res_t      r_add, r_pack, r_split, r_sel, r_q;
  logic          vld_q, take;

  assign eff_base = force_ten ? TEN : base;
  assign in_ready = !vld_q || out_ready;
  assign take     = in_valid && in_ready;

  aau_add_adj u_add (.ax(ax_in), .af_in(af_in), .legacy(legacy_mode), .res(r_add));
  aau_base_adj #(.SPLIT(1'b0)) u_pack  (.ax(ax_in), .b(eff_base), .res(r_pack));
  aau_base_adj #(.SPLIT(1'b1)) u_split (.ax(ax_in), .b(eff_base), .res(r_split));

  always_comb begin
    unique case (aau_op_e'(op))
      AAU_ADD:   r_sel = r_add;
      AAU_DPREP: r_sel = r_pack;
      AAU_MSPLT: r_sel = r_split;
      default: begin
        r_sel    = '0;
        r_sel.ax = ax_in;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      r_q   <= '0;
    end else if (take) begin
      vld_q <= 1'b1;
      r_q   <= r_sel;
    end else if (out_ready) begin
      vld_q <= 1'b0;
    end
  end

  assign out_valid = vld_q;
  assign ax_out    = r_q.ax;
  assign cf        = r_q.cf;
  assign af_out    = r_q.af;
  assign sf        = r_q.sf;
  assign zf        = r_q.zf;
  assign pf        = r_q.pf;
  assign div_err   = r_q.derr;

  AST_RESULT_NEXT_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> out_valid); // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(ax_out) && $stable(div_err) && $stable(cf))); // R10
  AST_ADD_NIBBLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 2'b00) |=> (ax_out[7:4] == 4'd0 && cf == af_out && !sf && !zf && !pf)); // R4
  AST_PACK_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 2'b01) |=> (ax_out[15:8] == 8'd0 && !cf && !af_out && !div_err)); // R5
  AST_ZERO_BASE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 2'b10 && eff_base == '0) |=> (div_err && ax_out == $past(ax_in))); // R8
  AST_SPLIT_REM_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && op == 2'b10 && eff_base != '0) |=> (!div_err && ax_out[7:0] < $past(eff_base))); // R6
endmodule

// File: tb/sim_ascii_adjust_unit.sv
module sim_ascii_adjust_unit;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, out_ready = 1, af_in = 0, legacy_mode = 0, force_ten = 0;
  logic [1:0] op = '0;
  logic [7:0] base = '0;
  logic [15:0] ax_in = '0;
  logic in_ready, out_valid, cf, af_out, sf, zf, pf, div_err;
  logic [15:0] ax_out;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ascii_adjust_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready), .op(op),
    .base(base), .ax_in(ax_in), .af_in(af_in), .legacy_mode(legacy_mode),
    .force_ten(force_ten), .out_valid(out_valid), .out_ready(out_ready),
    .ax_out(ax_out), .cf(cf), .af_out(af_out), .sf(sf), .zf(zf), .pf(pf),
    .div_err(div_err)
  );

  // {valid, ax, cf, af, sf, zf, pf, err}
  function automatic logic [22:0] model(input int o, input int b, input int ax,
                                        input int af, input int leg, input int ften);
    int hi, lo, e, c, a, s, z, p, er, ones;
    hi = (ax >> 8) & 255; lo = ax & 255; e = ften ? 10 : b;
    c = 0; a = 0; s = 0; z = 0; p = 0; er = 0;
    if (o == 0) begin
      if ((lo % 16) > 9 || af == 1) begin
        if (leg == 1) lo = (lo + 6) % 256;
        else begin
          ax = (hi * 256 + lo + 6) % 65536; hi = ax / 256; lo = ax % 256;
        end
        hi = (hi + 1) % 256; c = 1; a = 1;
      end
      lo = lo % 16;
    end else if (o == 1) begin
      lo = (hi * e + lo) % 256; hi = 0;
    end else if (o == 2) begin
      if (e == 0) er = 1;
      else begin hi = lo / e; lo = lo % e; end
    end
    if ((o == 1 || o == 2) && er == 0) begin
      ones = 0;
      for (int i = 0; i < 8; i++) ones += (lo >> i) & 1;
      s = lo / 128; z = (lo == 0) ? 1 : 0; p = (ones % 2 == 0) ? 1 : 0;
    end
    return {1'b1, 8'(hi), 8'(lo), 1'(c), 1'(a), 1'(s), 1'(z), 1'(p), 1'(er)};
  endfunction

  function automatic logic [22:0] seen();
    return {out_valid, ax_out, cf, af_out, sf, zf, pf, div_err};
  endfunction

  task automatic chk(input string req, input logic [22:0] got, input logic [22:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic run(input string req, input int o, input int b, input int ax,
                     input int af, input int leg, input int ften);
    @(negedge clk);
    op = 2'(o); base = 8'(b); ax_in = 16'(ax); af_in = 1'(af);
    legacy_mode = 1'(leg); force_ten = 1'(ften); in_valid = 1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk(req, seen(), model(o, b, ax, af, leg, ften));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", {in_ready, seen()}, {1'b1, 23'd0});
    rst_n = 1;

    for (int leg = 0; leg < 2; leg++)
      for (int af = 0; af < 2; af++)
        for (int h = 0; h < 3; h++)
          for (int lo = 0; lo < 256; lo++) begin
            int hv;
            hv = (h == 0) ? 0 : (h == 1) ? 127 : 255;
            if ((lo % 16) > 9 || af == 1) run(leg ? "R1 R3" : "R1 R2", 0, 0, hv * 256 + lo, af, leg, 0);
            else run("R1 R4 R9", 0, 0, hv * 256 + lo, af, leg, 0);
          end

    for (int k = 0; k < 4; k++)
      for (int hi = 0; hi < 256; hi++)
        for (int lo = 0; lo < 256; lo += 17) begin
          int bv;
          bv = (k == 0) ? 0 : (k == 1) ? 10 : (k == 2) ? 255 : 7;
          run("R5", 1, bv, hi * 256 + lo, 0, 0, 0);
        end

    for (int lo = 0; lo < 256; lo++)
      for (int b = 0; b < 256; b += 3)
        run(b == 0 ? "R8" : "R6", 2, b, 16'hA500 + lo, 0, 0, 0);

    for (int lo = 0; lo < 256; lo += 5) begin
      run("R7", 1, 3, 2 * 256 + lo, 0, 0, 1);
      run("R7", 2, 0, lo, 1, 0, 1);
      run("R9", 3, lo, 16'h5A00 + lo, 1, lo & 1, 0);
    end

    // back-pressure
    @(negedge clk);
    op = 2'd2; base = 8'd10; ax_in = 16'h0063; af_in = 0; legacy_mode = 0; force_ten = 0;
    in_valid = 1; out_ready = 0;
    @(posedge clk);
    @(negedge clk);
    op = 2'd1; base = 8'd10; ax_in = 16'h0304;
    for (int i = 0; i < 4; i++) begin
      chk("R10", {in_ready, seen()}, {1'b0, model(2, 10, 16'h0063, 0, 0, 0)});
      @(negedge clk);
    end
    out_ready = 1;
    chk("R10", {in_ready, seen()}, {1'b1, model(2, 10, 16'h0063, 0, 0, 0)});
    @(posedge clk);
    @(negedge clk);
    in_valid = 0;
    chk("R10", seen(), model(1, 10, 16'h0304, 0, 0, 0));
    @(negedge clk);
    chk("R10", {21'd0, out_valid, in_ready}, {21'd0, 1'b0, 1'b1});

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule